// File: doc/BRIEF.md
# Write-Only Audio Codec Register Sequencer

This block keeps a local mirror of the fourteen control registers of an audio codec that has no read path. It turns each register update into one or two byte transfers for a serial control-bus master. A register write is stored in the mirror first. Then, depending on the register group, the block emits either one transfer or an indirect pair of transfers. The pair carries the register index with one prefix and the value with another. Reads are served straight from the mirror through a combinational port.

Two housekeeping sequences sit beside plain writes. The reset sequence raises the codec's soft-reset bit in status register 0 and holds it for a programmable number of cycles. It then clears the bit again, and every other bit of that register is kept. The replay sequence pushes all fourteen mirror entries to the device in ascending index order, for use after the device has lost power.

The controller has four states:
- ST_IDLE waits for a command.
- ST_FIRST offers the only transfer, or the index transfer of an indirect pair.
- ST_SECOND offers the value transfer of a pair.
- ST_HOLD times the reset pulse.

The transitions are:
- IDLE→FIRST on an accepted command.
- FIRST→SECOND when the first half of a pair is taken.
- FIRST/SECOND→HOLD when the set half of a reset completes.
- FIRST/SECOND→FIRST for the next register of a replay.
- HOLD→FIRST when the hold count expires.
- FIRST/SECOND→IDLE when a sequence completes or the master times out.

Top module: `codec_seq`

## Requirements
- R1: After reset the mirror holds, for indices 0..13, the hex values 04,04,04,00,00,00,00,00,00,83,00,40,80,00. `rd_data` returns the mirror entry for `rd_idx` 0..13 and 8'hFF for any index of 14 or above.
- R2: Every transfer address is device number 5 in bits 7:2 with a group code in bits 1:0. The group code is 0 for indices 0..7 and 10..12, 1 for index 13, and 2 for indices 8 and 9. The resulting bytes are 8'h14, 8'h15 and 8'h16.
- R3: Indices 0..7 are indirect. A write to one of them gives two consecutive transfers to address 8'h14. The first carries 8'hC0 OR the index, and the second carries 8'hE0 OR the value.
- R4: Indices 8..13 are direct. A write to one of them gives exactly one transfer carrying the value unchanged.
- R5: The mirror takes the new value at the clock edge that accepts the write, before any transfer completes.
- R6: A write with index 14 or above is refused. It produces a one-cycle `err_range` pulse in the cycle after, no transfer, and no mirror change.
- R7: A reset command first sends status register 0 (address 8'h16) with bit 6 set, then sends it with bit 6 cleared. All other bits equal the mirror value, and afterwards the mirror holds the cleared value.
- R8: With an immediately accepting master, the clearing transfer of a reset is accepted `hold_len`+2 cycles after the setting transfer is accepted.
- R9: A replay command sends all fourteen registers in ascending index order, each formatted as in R3/R4, which makes 22 transfers in total.
- R10: Commands are taken only while `busy` is low. Requests raised while busy are ignored and change neither the mirror nor the transfer stream.
- R11: If a transfer is offered for TIMEOUT cycles without `xfer_ready`, the sequence is abandoned. `err_timeout` pulses for one cycle and `busy` falls in the same cycle.
- R12: When several requests arrive in the same idle cycle, reset wins over replay, and replay wins over write. The losing requests are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Register write request |
| wr_idx | input | 4 | Register index of the write |
| wr_data | input | 8 | Value of the write |
| rst_cmd | input | 1 | Start the soft-reset sequence |
| sync_cmd | input | 1 | Start the full replay sequence |
| hold_len | input | HOLD_W | Reset hold interval in cycles |
| rd_idx | input | 4 | Mirror read index |
| rd_data | output | 8 | Mirror read value (8'hFF when out of range) |
| busy | output | 1 | A sequence is in progress |
| err_range | output | 1 | Pulse: write index out of range |
| err_timeout | output | 1 | Pulse: master did not accept a transfer |
| xfer_valid | output | 1 | Transfer offered to the bus master |
| xfer_addr | output | 8 | Address byte of the transfer |
| xfer_byte | output | 8 | Data byte of the transfer |
| xfer_ready | input | 1 | Master accepts the offered transfer |

## Verification
The bench builds the block with TIMEOUT set to 6 and HOLD_W set to 8. With these values the abandon path is reached after a few stalled cycles. The reset pulse width can also be set to small exact values, so the gap between the two status transfers can be measured cycle for cycle. The bench also varies the master's acceptance delay. This keeps a sequence busy long enough for reads of the mirror and for ignored requests to fall inside it.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;

    localparam int          NUM_REGS    = 14;
    localparam int          IDX_W       = 4;
    localparam logic [3:0]  LAST_IDX    = 4'd13;
    localparam logic [3:0]  IND_LAST    = 4'd7;
    localparam logic [3:0]  STATUS0_IDX = 4'd8;
    localparam logic [3:0]  STATUS1_IDX = 4'd9;
    localparam logic [3:0]  DATA1_IDX   = 4'd13;
    localparam logic [5:0]  DEV_NUM     = 6'd5;
    localparam int          SRST_BIT    = 6;
    localparam logic [7:0]  TAG_INDEX   = 8'hC0;
    localparam logic [7:0]  TAG_VALUE   = 8'hE0;

    typedef enum logic [1:0] {
        GRP_DATA0  = 2'd0,
        GRP_DATA1  = 2'd1,
        GRP_STATUS = 2'd2
    } grp_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_FIRST, ST_SECOND, ST_HOLD
    } state_e;

    typedef enum logic [1:0] {
        OP_WRITE, OP_RST_SET, OP_RST_CLR, OP_SYNC
    } op_e;

    function automatic logic [7:0] power_on_value(input int i);
        case (i)
            0, 1, 2: power_on_value = 8'h04;
            9:       power_on_value = 8'h83;
            11:      power_on_value = 8'h40;
            12:      power_on_value = 8'h80;
            default: power_on_value = 8'h00;
        endcase
    endfunction

    function automatic grp_e group_of(input logic [3:0] idx);
        if (idx == STATUS0_IDX || idx == STATUS1_IDX) group_of = GRP_STATUS;
        else if (idx == DATA1_IDX)                     group_of = GRP_DATA1;
        else                                           group_of = GRP_DATA0;
    endfunction

endpackage

// File: rtl/codec_shadow.sv
module codec_shadow
    import codec_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    input  logic [IDX_W-1:0] fetch_idx,
    output logic [7:0]       fetch_data
);

    logic [7:0] mem [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[g] <= power_on_value(g);
            else if (we && widx == IDX_W'(g))
                mem[g] <= wdata;
        end
    end

    always_comb begin
        rd_data    = 8'hFF;
        fetch_data = 8'hFF;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IDX_W'(i))    rd_data    = mem[i];
            if (fetch_idx == IDX_W'(i)) fetch_data = mem[i];
        end
    end

endmodule

// File: rtl/codec_framer.sv
module codec_framer
    import codec_seq_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       value,
    input  logic             second,
    output logic             indirect,
    output logic [7:0]       addr,
    output logic [7:0]       data
);

    grp_e grp;

    always_comb begin
        indirect = (idx <= IND_LAST);
        grp      = group_of(idx);
        addr     = {DEV_NUM, grp};
        if (second)
            data = value | TAG_VALUE;
        else if (indirect)
            data = {4'h0, idx} | TAG_INDEX;
        else
            data = value;
    end

endmodule

// File: rtl/codec_seq.sv
module codec_seq
    import codec_seq_pkg::*;
#(
    parameter int TIMEOUT = 64,
    parameter int HOLD_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [3:0]        wr_idx,
    input  logic [7:0]        wr_data,
    input  logic              rst_cmd,
    input  logic              sync_cmd,
    input  logic [HOLD_W-1:0] hold_len,
    input  logic [3:0]        rd_idx,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              err_range,
    output logic              err_timeout,
    output logic              xfer_valid,
    output logic [7:0]        xfer_addr,
    output logic [7:0]        xfer_byte,
    input  logic              xfer_ready
);

    localparam int TMO_W = $clog2(TIMEOUT + 1);
    localparam int CNT_W = (HOLD_W > TMO_W) ? HOLD_W : TMO_W;
    localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TIMEOUT - 1);

    state_e           st, st_n;
    op_e              op, op_n;
    logic [3:0]       cur, cur_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             erng_n, etmo_n;

    logic             sh_we;
    logic [3:0]       sh_idx, fetch_idx;
    logic [7:0]       sh_wd, fetch_data;
    logic             indirect, taken, last;

    codec_shadow u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (sh_we),
        .widx      (sh_idx),
        .wdata     (sh_wd),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .fetch_idx (fetch_idx),
        .fetch_data(fetch_data)
    );

    codec_framer u_framer (
        .idx     (cur),
        .value   (fetch_data),
        .second  (st == ST_SECOND),
        .indirect(indirect),
        .addr    (xfer_addr),
        .data    (xfer_byte)
    );

    // Output process
    always_comb begin
        xfer_valid = (st == ST_FIRST) || (st == ST_SECOND);
        busy       = (st != ST_IDLE);
        fetch_idx  = xfer_valid ? cur : STATUS0_IDX;
    end

    assign taken = xfer_valid && xfer_ready;
    assign last  = (st == ST_SECOND) || !indirect;

    // Next-state process
    always_comb begin
        st_n   = st;
        op_n   = op;
        cur_n  = cur;
        cnt_n  = cnt;
        erng_n = 1'b0;
        etmo_n = 1'b0;
        sh_we  = 1'b0;
        sh_idx = cur;
        sh_wd  = fetch_data;
        unique case (st)
            ST_IDLE: begin
                cnt_n = '0;
                if (rst_cmd) begin
                    op_n   = OP_RST_SET;
                    cur_n  = STATUS0_IDX;
                    sh_we  = 1'b1;
                    sh_idx = STATUS0_IDX;
                    sh_wd  = fetch_data | (8'h1 << SRST_BIT);
                    st_n   = ST_FIRST;
                end else if (sync_cmd) begin
                    op_n  = OP_SYNC;
                    cur_n = 4'd0;
                    st_n  = ST_FIRST;
                end else if (wr_valid) begin
                    if (wr_idx <= LAST_IDX) begin
                        op_n   = OP_WRITE;
                        cur_n  = wr_idx;
                        sh_we  = 1'b1;
                        sh_idx = wr_idx;
                        sh_wd  = wr_data;
                        st_n   = ST_FIRST;
                    end else begin
                        erng_n = 1'b1;
                    end
                end
            end
            ST_FIRST, ST_SECOND: begin
                if (taken) begin
                    cnt_n = '0;
                    if (!last) begin
                        st_n = ST_SECOND;
                    end else begin
                        unique case (op)
                            OP_RST_SET: begin
                                st_n  = ST_HOLD;
                                cnt_n = CNT_W'(hold_len);
                            end
                            OP_SYNC: begin
                                if (cur == LAST_IDX) begin
                                    st_n = ST_IDLE;
                                end else begin
                                    cur_n = cur + 4'd1;
                                    st_n  = ST_FIRST;
                                end
                            end
                            OP_WRITE, OP_RST_CLR: st_n = ST_IDLE;
                        endcase
                    end
                end else if (cnt == TMO_LAST) begin
                    etmo_n = 1'b1;
                    st_n   = ST_IDLE;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            ST_HOLD: begin
                if (cnt == '0) begin
                    op_n   = OP_RST_CLR;
                    sh_we  = 1'b1;
                    sh_idx = STATUS0_IDX;
                    sh_wd  = fetch_data & ~(8'h1 << SRST_BIT);
                    st_n   = ST_FIRST;
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
        endcase
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            op          <= OP_WRITE;
            cur         <= 4'd0;
            cnt         <= '0;
            err_range   <= 1'b0;
            err_timeout <= 1'b0;
        end else begin
            st          <= st_n;
            op          <= op_n;
            cur         <= cur_n;
            cnt         <= cnt_n;
            err_range   <= erng_n;
            err_timeout <= etmo_n;
        end
    end

    // R3
    pair_value_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && xfer_byte[7:5] == 3'b110) |=>
            (xfer_valid && xfer_byte[7:5] == 3'b111 && xfer_addr == 8'h14));

    // R6
    refused_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_valid && !rst_cmd && !sync_cmd && wr_idx > LAST_IDX) |=>
            (err_range && !busy));

    // R7
    reset_set_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && op == OP_RST_SET) |-> (xfer_byte[SRST_BIT] && xfer_addr == 8'h16));

    // R7
    reset_clear_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && op == OP_RST_CLR) |-> (!xfer_byte[SRST_BIT] && xfer_addr == 8'h16));

    // R8
    hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && cnt != '0) |=> (st == ST_HOLD && !xfer_valid));

    // R9
    replay_ascends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && last && op == OP_SYNC && cur != LAST_IDX) |=>
            (xfer_valid && cur == $past(cur) + 4'd1));

    // R11
    timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> !busy);

endmodule

// File: tb/codec_seq_test.sv
module codec_seq_test;

    localparam int TMO = 6;
    localparam int HW  = 8;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          wr_valid = 0, rst_cmd = 0, sync_cmd = 0;
    logic [3:0]    wr_idx = 0, rd_idx = 0;
    logic [7:0]    wr_data = 0;
    logic [HW-1:0] hold_len = 0;
    logic [7:0]    rd_data, xfer_addr, xfer_byte;
    logic          busy, err_range, err_timeout, xfer_valid;
    logic          xfer_ready = 0;

    int errors = 0, checks = 0;
    int cyc = 0, dly = 0, wcnt = 0, hs_count = 0, prev_hs = 0, last_hs = 0;
    bit stall = 0;
    int model [14];
    logic [15:0] exp_q [$];

    codec_seq #(.TIMEOUT(TMO), .HOLD_W(HW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_idx(wr_idx),
        .wr_data(wr_data), .rst_cmd(rst_cmd), .sync_cmd(sync_cmd),
        .hold_len(hold_len), .rd_idx(rd_idx), .rd_data(rd_data), .busy(busy),
        .err_range(err_range), .err_timeout(err_timeout),
        .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_byte(xfer_byte),
        .xfer_ready(xfer_ready));

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] addr_of(input int i);
        if (i == 8 || i == 9) return 8'h16;
        if (i == 13)          return 8'h15;
        return 8'h14;
    endfunction

    function automatic void expect_reg(input int i);
        if (i <= 7) begin
            exp_q.push_back({8'h14, 8'hC0 | 8'(i)});
            exp_q.push_back({8'h14, 8'(model[i]) | 8'hE0});
        end else begin
            exp_q.push_back({addr_of(i), 8'(model[i])});
        end
    endfunction

    // bus master model: every handshake is compared with the prediction
    always @(negedge clk) begin
        xfer_ready = (xfer_valid && !stall && wcnt >= dly);
        if (xfer_valid) wcnt++; else wcnt = 0;
        #1;
        if (xfer_valid && xfer_ready) begin
            hs_count++;
            prev_hs = last_hs;
            last_hs = cyc + 1;
            wcnt = 0;
            if (exp_q.size() == 0) begin
                chk(0, "R10 unexpected transfer", {xfer_addr, xfer_byte}, 0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk({xfer_addr, xfer_byte} == e, "R2/R3/R4 transfer",
                    {xfer_addr, xfer_byte}, e);
            end
        end
    end

    task automatic wait_idle();
        for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
        #2;
    endtask

    task automatic pulse(input bit w, input bit r, input bit s, input int i, input int v);
        @(negedge clk);
        wr_valid = w; rst_cmd = r; sync_cmd = s;
        wr_idx = 4'(i); wr_data = 8'(v);
        @(negedge clk);
        #2;
        wr_valid = 0; rst_cmd = 0; sync_cmd = 0;
    endtask

    task automatic do_write(input int i, input int v);
        if (i < 14) begin model[i] = v; expect_reg(i); end
        pulse(1, 0, 0, i, v);
        wait_idle();
        chk(exp_q.size() == 0, "R3/R4 all transfers seen", exp_q.size(), 0);
    endtask

    task automatic check_mirror(input string tag);
        for (int i = 0; i < 16; i++) begin
            rd_idx = 4'(i);
            #1;
            chk(rd_data == ((i < 14) ? 8'(model[i]) : 8'hFF), tag, rd_data,
                (i < 14) ? model[i] : 255);
        end
    endtask

    initial begin
        #(200000 * 10);
        chk(0, "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        for (int i = 0; i < 14; i++) model[i] = 0;
        model[0] = 8'h04; model[1] = 8'h04; model[2] = 8'h04;
        model[9] = 8'h83; model[11] = 8'h40; model[12] = 8'h80;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !xfer_valid && !err_range && !err_timeout, "R1 idle after reset", busy, 0);
        check_mirror("R1 power-on mirror");

        // R4 / R2 direct registers in each group
        do_write(8, 8'h22);
        do_write(13, 8'h5C);
        do_write(10, 8'h3F);
        // R3 indirect registers
        do_write(7, 8'h1F);
        do_write(0, 8'hA5);
        check_mirror("R1 mirror after writes");

        // R6 refused index
        pulse(1, 0, 0, 14, 8'h99);
        chk(err_range && !busy, "R6 err_range pulse", err_range, 1);
        @(negedge clk);
        chk(!err_range, "R6 pulse is one cycle", err_range, 0);
        pulse(1, 0, 0, 15, 8'h99);
        chk(err_range && hs_count == 7, "R6 no transfer", hs_count, 7);
        check_mirror("R6 mirror unchanged");

        // R5 mirror updated before transfers finish
        dly = 4;
        model[11] = 8'h6D; expect_reg(11);
        pulse(1, 0, 0, 11, 8'h6D);
        rd_idx = 4'd11; #1;
        chk(busy && rd_data == 8'h6D, "R5 early mirror update", rd_data, 8'h6D);
        // R10 requests while busy are dropped
        model[2] = 8'h11; expect_reg(2);
        wait_idle();
        dly = 5;
        pulse(1, 0, 0, 2, 8'h11);
        pulse(1, 0, 0, 5, 8'h77);
        pulse(0, 0, 1, 0, 0);
        pulse(0, 1, 0, 0, 0);
        wait_idle();
        chk(exp_q.size() == 0, "R10 stream unchanged", exp_q.size(), 0);
        rd_idx = 4'd5; #1;
        chk(rd_data == 8'h00, "R10 busy write ignored", rd_data, 0);
        dly = 0;

        // R7 / R8 reset sequence
        hold_len = 8'd3;
        exp_q.push_back({8'h16, 8'h62});
        exp_q.push_back({8'h16, 8'h22});
        pulse(0, 1, 0, 0, 0);
        wait_idle();
        chk(exp_q.size() == 0, "R7 two status transfers", exp_q.size(), 0);
        chk(last_hs - prev_hs == 5, "R8 hold gap", last_hs - prev_hs, 5);
        rd_idx = 4'd8; #1;
        chk(rd_data == 8'h22, "R7 bit cleared in mirror", rd_data, 8'h22);
        hold_len = 8'd0;
        exp_q.push_back({8'h16, 8'h62});
        exp_q.push_back({8'h16, 8'h22});
        pulse(0, 1, 0, 0, 0);
        wait_idle();
        chk(last_hs - prev_hs == 2, "R8 zero hold gap", last_hs - prev_hs, 2);

        // R9 replay
        dly = 1;
        n = hs_count;
        for (int i = 0; i < 14; i++) expect_reg(i);
        pulse(0, 0, 1, 0, 0);
        wait_idle();
        chk(hs_count - n == 22, "R9 replay count", hs_count - n, 22);
        chk(exp_q.size() == 0, "R9 replay order", exp_q.size(), 0);
        dly = 0;

        // R12 priority
        exp_q.push_back({8'h16, 8'h62});
        exp_q.push_back({8'h16, 8'h22});
        pulse(1, 1, 1, 12, 8'hEE);
        wait_idle();
        chk(exp_q.size() == 0, "R12 reset wins", exp_q.size(), 0);
        n = hs_count;
        for (int i = 0; i < 14; i++) expect_reg(i);
        pulse(1, 0, 1, 12, 8'hEE);
        wait_idle();
        chk(hs_count - n == 22, "R12 replay beats write", hs_count - n, 22);
        check_mirror("R12 write dropped");

        // R11 timeout
        stall = 1;
        model[9] = 8'h5A;
        n = 0;
        @(negedge clk);
        wr_valid = 1; wr_idx = 4'd9; wr_data = 8'h5A;
        @(negedge clk);
        wr_valid = 0;
        for (int k = 0; k < 50 && !err_timeout; k++) begin
            if (xfer_valid) n++;
            @(negedge clk);
        end
        #2;
        chk(err_timeout && !busy, "R11 abandon", err_timeout, 1);
        chk(n == TMO, "R11 offered cycles", n, TMO);
        @(negedge clk);
        chk(!err_timeout, "R11 one-cycle pulse", err_timeout, 0);
        stall = 0;
        check_mirror("R11 mirror kept");
        do_write(4, 8'h09);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule